// File: doc/BRIEF.md
# Prefetch Candidate Queue Manager

This block sits between a hardware prefetch address generator and the memory-request arbiter of a cache. After each demand miss, the generator supplies a short burst of candidate addresses, one per cycle, each with a delay relative to that miss. The manager drops candidates that would be redundant. It stamps each surviving candidate with a ready time and appends it to a small ordered queue. While the queue holds anything, it raises a bus-request flag.

When the arbiter asks for work, the oldest entry is handed over. In filter-at-issue mode, an entry found in the cache is discarded at this point instead of being issued. Demand misses also act on the queue: a miss cancels the queued prefetch for the same block. In serial-squash mode, a miss also discards the newest entries whose ready time is not earlier than the miss time.

Cache-presence and miss-buffer lookups are external. The block drives a lookup address and expects the answer in the same cycle.

Top module: `pfq_manager`

## Requirements
- R1: A miss with `miss_uncached`=1 is ignored. When `cfg_data_only`=1, a miss with `miss_ifetch`=1 is also ignored. An ignored miss leaves the queue, the squash logic and the time base untouched.
- R2: Addresses are reduced to block addresses by clearing their low log2(BLK_BYTES) bits. All matching uses block addresses. Every address output has those bits at zero.
- R3: An accepted miss removes the queued entry with the same block address, if there is one, and pulses `ev_miss_removed`. The entries behind it keep their order.
- R4: With `cfg_serial_squash`=1, an accepted miss at time T runs after the cancellation in R3. It removes entries from the tail for as long as the tail's ready time is at least T (unsigned). It stops at the first earlier entry. `ev_squashed` gives the number removed.
- R5: A candidate's ready time is the time of the last accepted miss plus `cand_delay`, modulo 2^TIME_W. Entries leave the queue in insertion order.
- R6: A candidate is dropped if the miss buffer holds its block, or if the queue already holds its block. When `cfg_filter_at_push`=1, it is also dropped if the cache holds its block. The queue never contains two entries with the same block address.
- R7: A candidate inserted into a full queue (DEPTH entries) first discards the head entry and pulses `ev_evicted`. The count stays at DEPTH.
- R8: With `issue_req`=1 and a non-empty queue, the head entry is popped. If `cfg_filter_at_push`=0 and `head_in_cache`=1, the entry is discarded and `ev_issue_dropped` pulses. Otherwise `issue_valid` is raised with the head's address and ready time.
- R9: `bus_req` is registered. It becomes 1 after any insertion, with `bus_req_time` set to that entry's ready time. It becomes 0 when the queue becomes empty.
- R10: Only one action happens per cycle. An accepted miss beats a candidate. A candidate (even one that is dropped) beats an issue request.
- R11: `ev_identified` pulses for each candidate that is considered. `ev_dup_queued` pulses when a candidate passes the cache check (when that check applies) and the miss-buffer check, and is then found already queued.
- R12: After reset the queue is empty, `bus_req`=0, and `issue_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch misses |
| cfg_serial_squash | input | 1 | Enable tail squash on a miss |
| cfg_filter_at_push | input | 1 | 1: cache filter at insertion, 0: at issue |
| miss_valid | input | 1 | Demand miss event |
| miss_addr | input | ADDR_W | Miss address |
| miss_time | input | TIME_W | Miss time |
| miss_uncached | input | 1 | Miss is uncacheable |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate present |
| cand_addr | input | ADDR_W | Candidate address |
| cand_delay | input | DLY_W | Candidate delay relative to the miss |
| cand_look_addr | output | ADDR_W | Candidate block address for lookups |
| cand_in_cache | input | 1 | Cache holds the candidate block |
| cand_in_mshr | input | 1 | Miss buffer holds the candidate block |
| head_look_addr | output | ADDR_W | Head block address for cache lookup |
| head_in_cache | input | 1 | Cache holds the head block |
| issue_req | input | 1 | Arbiter asks for a prefetch |
| issue_valid | output | 1 | Head entry issued this cycle |
| issue_addr | output | ADDR_W | Issued block address |
| issue_time | output | TIME_W | Issued ready time |
| bus_req | output | 1 | Queue holds entries |
| bus_req_time | output | TIME_W | Ready time of the latest insertion |
| ev_identified | output | 1 | Candidate considered |
| ev_dup_queued | output | 1 | Candidate already queued |
| ev_evicted | output | 1 | Head dropped for room |
| ev_miss_removed | output | 1 | Entry cancelled by a miss |
| ev_squashed | output | CNT_W | Entries squashed this cycle |
| ev_issue_dropped | output | 1 | Head discarded at issue (in cache) |

## Verification
The assertions check four things on every cycle:
- the count never exceeds DEPTH and an eviction keeps it at DEPTH;
- a pop lowers the count by one;
- after a squash the tail's ready time is earlier than the miss time;
- no block is ever queued twice, `bus_req` tracks a non-empty queue, an ignored miss leaves the count alone, and an accepted miss blocks issue.

Only the bench's scenarios can show the rest, because it depends on contents and ordering:
- which entry a miss cancels and how many the squash removes;
- that ready times are sums of the right base and delay;
- that entries leave in insertion order, so the right head is evicted;
- that the filter rules drop the right candidates in each mode.

// File: rtl/pfq_pkg.sv
// Shared types for the prefetch queue manager.
// Assumes: one queue action per cycle, chosen by the top module.
package pfq_pkg;
    typedef enum logic [1:0] {
        PFQ_IDLE = 2'd0,
        PFQ_MISS = 2'd1,
        PFQ_PUSH = 2'd2,
        PFQ_POP  = 2'd3
    } pfq_op_e;
endpackage

// File: rtl/pfq_match.sv
// Parallel block-address comparator over all queue slots.
// Reports whether any valid slot equals the key, and the lowest matching index.
// Assumes: keys and tags are already block-aligned.
module pfq_match #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [ADDR_W-1:0]             key,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  tags,
    input  logic [DEPTH-1:0]              vld,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    logic [DEPTH-1:0] hit_vec;

    // One comparator per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key);
    end

    // Reduce the hit vector to a flag and a lowest-first index.
    always_comb begin
        hit = |hit_vec;
        idx = '0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pfq_store.sv
// Ordered register-array queue. Slot 0 is the head (oldest).
// Supports four actions: miss (cancel one slot, then optionally squash from
// the tail), push (append, evicting the head when full), pop (drop the head)
// and idle.
// Assumes: the caller requests a pop only when count > 0, and requests a
// cancellation only for a valid slot.
module pfq_store
    import pfq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int TIME_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  pfq_op_e                       op,
    input  logic                          rm_hit,
    input  logic [IDX_W-1:0]              rm_idx,
    input  logic                          sq_en,
    input  logic [TIME_W-1:0]             sq_time,
    input  logic [ADDR_W-1:0]             in_tag,
    input  logic [TIME_W-1:0]             in_time,
    output logic [DEPTH-1:0][ADDR_W-1:0]  tags,
    output logic [DEPTH-1:0]              vld,
    output logic [TIME_W-1:0]             head_time,
    output logic [CNT_W-1:0]              count,
    output logic [CNT_W-1:0]              count_nxt,
    output logic                          full,
    output logic [CNT_W-1:0]              sq_num
);
    logic [DEPTH-1:0][ADDR_W-1:0] tag_q, tag_d, c_tag;
    logic [DEPTH-1:0][TIME_W-1:0] time_q, time_d, c_time;
    logic [CNT_W-1:0]             cnt_q, cnt_d, c_cnt, sq_n;
    logic                         sq_stop;

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign tags      = tag_q;
    assign head_time = time_q[0];
    assign count     = cnt_q;
    assign count_nxt = cnt_d;

    // Slot valid bits follow from the fill count.
    for (genvar g = 0; g < DEPTH; g++) begin : g_vld
        assign vld[g] = (CNT_W'(g) < cnt_q);
    end

    // Compact out the cancelled slot, then count the squashable tail run.
    always_comb begin
        c_tag = tag_q;
        c_time = time_q;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (rm_hit && (IDX_W'(i) >= rm_idx)) begin
                c_tag[i]  = tag_q[i+1];
                c_time[i] = time_q[i+1];
            end
        end
        c_cnt = cnt_q - CNT_W'(rm_hit);
        sq_n = '0;
        sq_stop = 1'b0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if (!sq_stop && (CNT_W'(i) < c_cnt)) begin
                if (c_time[i] >= sq_time) sq_n = sq_n + 1'b1;
                else                      sq_stop = 1'b1;
            end
        end
    end

    // Next-state selection for the chosen action.
    always_comb begin
        tag_d  = tag_q;
        time_d = time_q;
        cnt_d  = cnt_q;
        sq_num = '0;
        unique case (op)
            PFQ_MISS: begin
                tag_d  = c_tag;
                time_d = c_time;
                sq_num = sq_en ? sq_n : '0;
                cnt_d  = c_cnt - sq_num;
            end
            PFQ_PUSH: begin
                if (full) begin
                    for (int i = 0; i < DEPTH - 1; i++) begin
                        tag_d[i]  = tag_q[i+1];
                        time_d[i] = time_q[i+1];
                    end
                    tag_d[DEPTH-1]  = in_tag;
                    time_d[DEPTH-1] = in_time;
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CNT_W'(i) == cnt_q) begin
                            tag_d[i]  = in_tag;
                            time_d[i] = in_time;
                        end
                    end
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PFQ_POP: begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    tag_d[i]  = tag_q[i+1];
                    time_d[i] = time_q[i+1];
                end
                cnt_d = cnt_q - 1'b1;
            end
            default: ;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            time_q <= '0;
            cnt_q  <= '0;
        end else begin
            tag_q  <= tag_d;
            time_q <= time_d;
            cnt_q  <= cnt_d;
        end
    end

    // Checker helpers: ready time of the tail slot and pairwise duplicate detect.
    logic [TIME_W-1:0] tail_time;
    logic              dup_any;
    always_comb begin
        tail_time = time_q[0];
        dup_any = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i + 1) == cnt_q) tail_time = time_q[i];
            for (int j = i + 1; j < DEPTH; j++) begin
                if (vld[i] && vld[j] && (tag_q[i] == tag_q[j])) dup_any = 1'b1;
            end
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R7
    AST_EVICT_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PFQ_PUSH && full) |=> (cnt_q == CNT_W'(DEPTH))); // R7
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PFQ_POP) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
    AST_SQUASH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == PFQ_MISS && sq_en) |=> ((cnt_q == '0) || (tail_time < $past(sq_time)))); // R4
    AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_any); // R6
endmodule

// File: rtl/pfq_manager.sv
// Prefetch candidate queue manager (top).
// Filters candidates, stamps ready times, applies miss cancellation/squash,
// and hands the head entry to the arbiter. Lookups to the cache and miss
// buffer are external and combinational.
// Assumes: DLY_W <= TIME_W; BLK_BYTES is a power of two; configuration
// inputs change only while reset is held.
module pfq_manager
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int ADDR_W    = 16,
    parameter int TIME_W    = 16,
    parameter int DLY_W     = 8,
    parameter int BLK_BYTES = 16,
    localparam int OFS_W = $clog2(BLK_BYTES),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_data_only,
    input  logic              cfg_serial_squash,
    input  logic              cfg_filter_at_push,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [TIME_W-1:0] miss_time,
    input  logic              miss_uncached,
    input  logic              miss_ifetch,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic [DLY_W-1:0]  cand_delay,
    output logic [ADDR_W-1:0] cand_look_addr,
    input  logic              cand_in_cache,
    input  logic              cand_in_mshr,
    output logic [ADDR_W-1:0] head_look_addr,
    input  logic              head_in_cache,
    input  logic              issue_req,
    output logic              issue_valid,
    output logic [ADDR_W-1:0] issue_addr,
    output logic [TIME_W-1:0] issue_time,
    output logic              bus_req,
    output logic [TIME_W-1:0] bus_req_time,
    output logic              ev_identified,
    output logic              ev_dup_queued,
    output logic              ev_evicted,
    output logic              ev_miss_removed,
    output logic [CNT_W-1:0]  ev_squashed,
    output logic              ev_issue_dropped
);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'((1 << OFS_W) - 1);

    logic [DEPTH-1:0][ADDR_W-1:0] q_tags;
    logic [DEPTH-1:0]             q_vld;
    logic [TIME_W-1:0]            q_head_time, base_q, cand_rt, req_time_q;
    logic [CNT_W-1:0]             q_cnt, q_cnt_nxt, sq_num;
    logic                         q_full, req_q;
    logic [ADDR_W-1:0]            miss_blk, cand_blk, key;
    logic                         miss_acc, cand_go, cand_cache_drop, mhit;
    logic                         pop_go, ins_go;
    logic [IDX_W-1:0]             midx;
    pfq_op_e                      op;

    // Block-align the incoming addresses and qualify the miss.
    always_comb begin
        miss_blk = miss_addr & BLK_MASK;
        cand_blk = cand_addr & BLK_MASK;
        miss_acc = miss_valid && !miss_uncached && !(cfg_data_only && miss_ifetch);
        cand_rt  = base_q + TIME_W'(cand_delay);
        key      = miss_acc ? miss_blk : cand_blk;
    end

    // One comparator bank serves both the miss cancel and the duplicate check.
    pfq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) match_i (
        .key(key), .tags(q_tags), .vld(q_vld), .hit(mhit), .idx(midx)
    );

    // Candidate filtering, issue decision and action selection.
    always_comb begin
        cand_go         = cand_valid && !miss_acc;
        cand_cache_drop = cfg_filter_at_push && cand_in_cache;
        ins_go          = cand_go && !cand_cache_drop && !cand_in_mshr && !mhit;
        pop_go          = issue_req && !miss_acc && !cand_valid && (q_cnt != '0);
        issue_valid     = pop_go && (cfg_filter_at_push || !head_in_cache);
        if (miss_acc)    op = PFQ_MISS;
        else if (ins_go) op = PFQ_PUSH;
        else if (pop_go) op = PFQ_POP;
        else             op = PFQ_IDLE;
    end

    pfq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TIME_W(TIME_W)) store_i (
        .clk(clk), .rst_n(rst_n), .op(op),
        .rm_hit(miss_acc && mhit), .rm_idx(midx),
        .sq_en(cfg_serial_squash), .sq_time(miss_time),
        .in_tag(cand_blk), .in_time(cand_rt),
        .tags(q_tags), .vld(q_vld), .head_time(q_head_time),
        .count(q_cnt), .count_nxt(q_cnt_nxt), .full(q_full), .sq_num(sq_num)
    );

    // Time base of the latest accepted miss, and the bus-request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            req_q      <= 1'b0;
            req_time_q <= '0;
        end else begin
            if (miss_acc) base_q <= miss_time;
            if (ins_go) begin
                req_q      <= 1'b1;
                req_time_q <= cand_rt;
            end else if (q_cnt_nxt == '0) begin
                req_q <= 1'b0;
            end
        end
    end

    // Output and event wiring.
    always_comb begin
        cand_look_addr   = cand_blk;
        head_look_addr   = q_tags[0];
        issue_addr       = q_tags[0];
        issue_time       = q_head_time;
        bus_req          = req_q;
        bus_req_time     = req_time_q;
        ev_identified    = cand_go;
        ev_dup_queued    = cand_go && !cand_cache_drop && !cand_in_mshr && mhit;
        ev_evicted       = ins_go && q_full;
        ev_miss_removed  = miss_acc && mhit;
        ev_squashed      = sq_num;
        ev_issue_dropped = pop_go && !issue_valid;
    end

    AST_REQ_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req == (q_cnt != '0)); // R9
    AST_IGNORED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_uncached && !cand_valid && !issue_req) |=> $stable(q_cnt)); // R1
    AST_MISS_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        miss_acc |-> !issue_valid); // R10
endmodule

// File: tb/pfq_manager_tb.sv
`timescale 1ns/1ps
module pfq_manager_tb_top;
    localparam int DEPTH = 4, ADDR_W = 12, TIME_W = 10, DLY_W = 5, BLK_BYTES = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int TMASK = (1 << TIME_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_do = 0, cfg_sq = 0, cfg_push = 0;
    logic miss_valid = 0, miss_uncached = 0, miss_ifetch = 0;
    logic [ADDR_W-1:0] miss_addr = '0, cand_addr = '0;
    logic [TIME_W-1:0] miss_time = '0;
    logic cand_valid = 0, cand_in_cache = 0, cand_in_mshr = 0, head_in_cache = 0, issue_req = 0;
    logic [DLY_W-1:0] cand_delay = '0;
    logic [ADDR_W-1:0] cand_look_addr, head_look_addr, issue_addr;
    logic issue_valid, bus_req, ev_identified, ev_dup_queued, ev_evicted, ev_miss_removed, ev_issue_dropped;
    logic [TIME_W-1:0] issue_time, bus_req_time;
    logic [CNT_W-1:0] ev_squashed;

    always #2 clk = ~clk;

    pfq_manager #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TIME_W(TIME_W), .DLY_W(DLY_W), .BLK_BYTES(BLK_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_data_only(cfg_do), .cfg_serial_squash(cfg_sq),
        .cfg_filter_at_push(cfg_push), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .miss_time(miss_time), .miss_uncached(miss_uncached), .miss_ifetch(miss_ifetch),
        .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_delay(cand_delay),
        .cand_look_addr(cand_look_addr), .cand_in_cache(cand_in_cache), .cand_in_mshr(cand_in_mshr),
        .head_look_addr(head_look_addr), .head_in_cache(head_in_cache), .issue_req(issue_req),
        .issue_valid(issue_valid), .issue_addr(issue_addr), .issue_time(issue_time),
        .bus_req(bus_req), .bus_req_time(bus_req_time), .ev_identified(ev_identified),
        .ev_dup_queued(ev_dup_queued), .ev_evicted(ev_evicted), .ev_miss_removed(ev_miss_removed),
        .ev_squashed(ev_squashed), .ev_issue_dropped(ev_issue_dropped)
    );

    int n_cmp = 0, n_bad = 0, salt = 0;
    bit done = 0;
    // Reference queue (block numbers and ready times), head at index 0.
    int m_tag[DEPTH], m_time[DEPTH], m_cnt, m_base, m_req, m_reqt;
    int unsigned lfsr = 32'h1ACE_B00C;

    function automatic bit in_c(int b); return ((b * 5 + salt) % 7) == 0; endfunction
    function automatic bit in_m(int b); return (b % 11) == 5; endfunction

    task automatic chk(int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_base = 0; m_req = 0; m_reqt = 0;
        for (int i = 0; i < DEPTH; i++) begin m_tag[i] = 0; m_time[i] = 0; end
    endtask

    task automatic shift_from(int k);
        for (int i = k; i < DEPTH - 1; i++) begin m_tag[i] = m_tag[i+1]; m_time[i] = m_time[i+1]; end
    endtask

    // One cycle: drive, predict, check the combinational outputs, update the model.
    task automatic step(bit mv, int ma, int mt, bit mu, bit mi, bit cv, int ca, int cd, bit ir, string pfx);
        int cb, mb, found, e_iv, e_ia, e_it, e_dup, e_ev, e_rm, e_sq, e_drop, macc, cgo, popgo, ins, rt;
        @(negedge clk);
        chk(bus_req, m_req, {pfx, " R9 bus_req"});
        if (m_req != 0) chk(bus_req_time, m_reqt, {pfx, " R9 bus_req_time"});
        cb = (ca & ((1 << ADDR_W) - 1)) >> 4;
        mb = (ma & ((1 << ADDR_W) - 1)) >> 4;
        miss_valid = mv; miss_addr = ADDR_W'(ma); miss_time = TIME_W'(mt);
        miss_uncached = mu; miss_ifetch = mi;
        cand_valid = cv; cand_addr = ADDR_W'(ca); cand_delay = DLY_W'(cd);
        cand_in_cache = in_c(cb); cand_in_mshr = in_m(cb); issue_req = ir;
        head_in_cache = (m_cnt > 0) ? in_c(m_tag[0]) : 1'b0;
        macc = mv && !mu && !(cfg_do && mi);
        cgo = cv && !macc;
        popgo = ir && !macc && !cv && (m_cnt > 0);
        e_iv = popgo && (cfg_push || !in_c(m_tag[0]));
        e_ia = m_tag[0] << 4; e_it = m_time[0];
        e_drop = popgo && !e_iv;
        found = -1;
        for (int i = 0; i < m_cnt; i++) if (m_tag[i] == (macc ? mb : cb)) found = i;
        e_dup = cgo && !(cfg_push && in_c(cb)) && !in_m(cb) && (found >= 0);
        ins = cgo && !(cfg_push && in_c(cb)) && !in_m(cb) && (found < 0);
        e_ev = ins && (m_cnt == DEPTH);
        e_rm = macc && (found >= 0);
        e_sq = 0;
        rt = (m_base + cd) & TMASK;
        // Model update.
        if (macc) begin
            m_base = mt & TMASK;
            if (found >= 0) begin shift_from(found); m_cnt--; end
            if (cfg_sq) while (m_cnt > 0 && m_time[m_cnt-1] >= (mt & TMASK)) begin m_cnt--; e_sq++; end
        end else if (ins) begin
            if (m_cnt == DEPTH) begin shift_from(0); m_cnt--; end
            m_tag[m_cnt] = cb; m_time[m_cnt] = rt; m_cnt++;
        end else if (popgo) begin
            shift_from(0); m_cnt--;
        end
        if (ins) begin m_req = 1; m_reqt = rt; end
        else if (m_cnt == 0) m_req = 0;
        #1;
        chk(cand_look_addr, cb << 4, {pfx, " R2 cand_look_addr"});
        chk(issue_valid, e_iv, {pfx, " R8 issue_valid"});
        if (e_iv) begin
            chk(issue_addr, e_ia, {pfx, " R8 issue_addr"});
            chk(issue_time, e_it, {pfx, " R5 issue_time"});
        end
        chk(ev_issue_dropped, e_drop, {pfx, " R8 ev_issue_dropped"});
        chk(ev_identified, cgo, {pfx, " R11 ev_identified"});
        chk(ev_dup_queued, e_dup, {pfx, " R6 ev_dup_queued"});
        chk(ev_evicted, e_ev, {pfx, " R7 ev_evicted"});
        chk(ev_miss_removed, e_rm, {pfx, " R3 ev_miss_removed"});
        chk(ev_squashed, e_sq, {pfx, " R4 ev_squashed"});
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0, "IDLE"); endtask

    task automatic drain(string pfx);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1, pfx);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic int rnd();
        lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
        return int'(lfsr & 32'h7FFF_FFFF);
    endfunction

    initial begin
        #(4ns * 190000);
        n_bad++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        summary();
    end

    initial begin
        for (int cfg = 0; cfg < 8; cfg++) begin
            cfg_do = cfg[0]; cfg_sq = cfg[1]; cfg_push = cfg[2]; salt = cfg;
            rst_n = 0;
            repeat (3) @(posedge clk);
            model_reset();
            @(negedge clk); rst_n = 1;
            // R12: empty after reset, nothing to issue.
            step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R12");
            // Miss at t=100 then a candidate burst that overfills the queue.
            step(1, 12'h203, 100, 0, 0, 0, 0, 0, 0, "R5");
            for (int k = 1; k <= 6; k++) step(0, 0, 0, 0, 0, 1, (k << 4) | k, k * 3, 0, "R7");
            // Duplicate offer with a different byte offset.
            step(0, 0, 0, 0, 0, 1, 12'h04F, 1, 0, "R6");
            // Uncacheable and instruction-fetch misses to queued blocks.
            step(1, 12'h048, 0, 1, 0, 0, 0, 0, 0, "R1");
            step(1, 12'h058, 0, 0, 1, 0, 0, 0, 0, "R1");
            // Miss racing a candidate and an issue request.
            step(1, 12'h069, 103, 0, 0, 1, 12'h0A0, 2, 1, "R10");
            step(0, 0, 0, 0, 0, 1, 12'h0B0, 9, 1, "R10");
            step(0, 0, 0, 0, 0, 1, 12'h0C0, 0, 0, "R3");
            step(1, 12'h0B7, 101, 0, 0, 0, 0, 0, 0, "R3");
            drain("R8");
            // Pseudo-random phase over a small block range.
            for (int n = 0; n < 600; n++) begin
                int r = rnd();
                int op = r % 10;
                int a = (((r >> 4) % 14) << 4) | ((r >> 9) & 15);
                int t = (n * 3 + ((r >> 13) % 20)) & TMASK;
                if (op < 2)      step(1, a, t, (r >> 20) % 5 == 0, (r >> 21) % 3 == 0, (r >> 22) & 1, a ^ 12'h030, r % 31, (r >> 23) & 1, "RND");
                else if (op < 6) step(0, 0, 0, 0, 0, 1, a, (r >> 24) % 32, 0, "RND");
                else if (op < 9) step(0, 0, 0, 0, 0, 0, 0, 0, 1, "RND");
                else             idle();
            end
            drain("R8");
            idle();
        end
        summary();
    end
endmodule